// File: doc/BRIEF.md
# Set/Clear GPIO Register Port

This block is a 32-pin general-purpose I/O peripheral behind a simple 32-bit register port. Each pin drives a bidirectional pad through an output level, an output-enable and an input path. Software never writes the output level or the enable word directly. It writes a mask to a set strobe or a clear strobe, and only the pins with a 1 in the mask change. One pin can therefore change without a read-modify-write, and two agents sharing the port cannot undo each other's bits.

The input register returns the pad levels after a two-flop synchronizer. For a pin whose driver is on, it returns the level the block drives. For a pin whose driver is off, it returns the external level. Reads return data one cycle after the request. All state resets to outputs low with every driver off.

Top module: `gpio_setclr_port`

## Requirements
- R1: A write to word address 0x00 sets the output level to 1 for each pin whose data bit is 1. Pins whose bit is 0 keep their level. The new level appears on pad_o after the clock edge that accepts the write.
- R2: A write to word address 0x04 clears the output level to 0 for each pin whose data bit is 1. Pins whose bit is 0 keep their level.
- R3: A write to word address 0x08 turns the driver on (pad_oe_o bit = 1) for each pin whose data bit is 1. Other pins keep their enable.
- R4: A write to word address 0x0C turns the driver off (pad_oe_o bit = 0, pad tristated) for each pin whose data bit is 1. Other pins keep their enable.
- R5: A read of word address 0x10 returns one bit per pin, with bit n giving pin n. A pin whose driver is on returns its own output level. A pin whose driver is off returns the synchronized level of pad_i.
- R6: pad_i passes through two synchronizing flops. A read accepted at the first clock edge after pad_i changes returns the old level. A read accepted at the third edge or later returns the new level.
- R7: After reset, pad_o is all 0, pad_oe_o is all 0 and rdata_o is 0.
- R8: Reads of word address 0x00 or 0x04 return the current output levels. Reads of 0x08 or 0x0C return the current enable word.
- R9: Reads of any other word address return 0. Writes to any other word address change neither pad_o nor pad_oe_o.
- R10: rdata_o updates at the clock edge that accepts a read (req_i=1, we_i=0). It holds its value in every other cycle, writes included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Word address |
| wdata_i | input | 32 | Write mask |
| rdata_o | output | 32 | Read data, registered |
| pad_i | input | 32 | External pad levels |
| pad_o | output | 32 | Output level per pin |
| pad_oe_o | output | 32 | Output driver enable per pin |

## Verification
Writes take effect on pad_o and pad_oe_o at the edge that accepts them. Read data is due at the edge that accepts the read. The bench drives and samples on falling edges, so each result is checked half a cycle after the edge that should produce it. The synchronizer delay is checked at both ends. A read issued together with a pad change must still return the old level, and a read issued three edges later must return the new one. The hold behaviour of rdata_o is checked after idle cycles and after writes.

// File: rtl/gpio_setclr_pkg.sv
package gpio_setclr_pkg;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_OUT_SET = 5'h00;
  localparam logic [ADDR_W-1:0] A_OUT_CLR = 5'h04;
  localparam logic [ADDR_W-1:0] A_OE_SET  = 5'h08;
  localparam logic [ADDR_W-1:0] A_OE_CLR  = 5'h0C;
  localparam logic [ADDR_W-1:0] A_PIN_IN  = 5'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_OUT,
    SEL_OE,
    SEL_IN
  } rd_sel_e;

  typedef struct packed {
    logic out_set;
    logic out_clr;
    logic oe_set;
    logic oe_clr;
  } wr_strb_t;
endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_setclr_pkg::*;
(
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_strb_t          strb_o,
  output logic              rd_en_o,
  output rd_sel_e           rd_sel_o
);
  logic wr;
  assign wr      = req_i & we_i;
  assign rd_en_o = req_i & ~we_i;

  always_comb begin
    strb_o.out_set = wr && (addr_i == A_OUT_SET);
    strb_o.out_clr = wr && (addr_i == A_OUT_CLR);
    strb_o.oe_set  = wr && (addr_i == A_OE_SET);
    strb_o.oe_clr  = wr && (addr_i == A_OE_CLR);
  end

  always_comb begin
    unique case (addr_i)
      A_OUT_SET, A_OUT_CLR: rd_sel_o = SEL_OUT;
      A_OE_SET,  A_OE_CLR:  rd_sel_o = SEL_OE;
      A_PIN_IN:             rd_sel_o = SEL_IN;
      default:              rd_sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
  import gpio_setclr_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  wr_strb_t            strb_i,
  input  logic [NUM_PINS-1:0] mask_i,
  output logic [NUM_PINS-1:0] out_q_o,
  output logic [NUM_PINS-1:0] oe_q_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic hit_out_set, hit_out_clr, hit_oe_set, hit_oe_clr;
    assign hit_out_set = strb_i.out_set & mask_i[p];
    assign hit_out_clr = strb_i.out_clr & mask_i[p];
    assign hit_oe_set  = strb_i.oe_set  & mask_i[p];
    assign hit_oe_clr  = strb_i.oe_clr  & mask_i[p];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        out_q_o[p] <= 1'b0;
      end else if (hit_out_set) begin
        out_q_o[p] <= 1'b1;
      end else if (hit_out_clr) begin
        out_q_o[p] <= 1'b0;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        oe_q_o[p] <= 1'b0;
      end else if (hit_oe_set) begin
        oe_q_o[p] <= 1'b1;
      end else if (hit_oe_clr) begin
        oe_q_o[p] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q[0] <= '0;
    end else begin
      stage_q[0] <= d_i;
    end
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
  import gpio_setclr_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_oe_o
);
  wr_strb_t            strb;
  logic                rd_en;
  rd_sel_e             rd_sel;
  logic [NUM_PINS-1:0] out_q, oe_q, pad_sync, pin_lvl, rd_mux;

  gpio_reg_decode i_decode (
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .strb_o  (strb),
    .rd_en_o (rd_en),
    .rd_sel_o(rd_sel)
  );

  gpio_pin_bank #(.NUM_PINS(NUM_PINS)) i_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .strb_i (strb),
    .mask_i (wdata_i),
    .out_q_o(out_q),
    .oe_q_o (oe_q)
  );

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (pad_sync)
  );

  // driven pins report their own level, tristated pins the outside world
  assign pin_lvl = (oe_q & out_q) | (~oe_q & pad_sync);

  always_comb begin
    unique case (rd_sel)
      SEL_OUT: rd_mux = out_q;
      SEL_OE:  rd_mux = oe_q;
      SEL_IN:  rd_mux = pin_lvl;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (rd_en) begin
      rdata_o <= rd_mux;
    end
  end

  assign pad_o    = out_q;
  assign pad_oe_o = oe_q;
endmodule

// File: rtl/gpio_setclr_chk.sv
module gpio_setclr_chk
  import gpio_setclr_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [NUM_PINS-1:0] wdata_i,
  input logic [NUM_PINS-1:0] rdata_o,
  input logic [NUM_PINS-1:0] pad_o,
  input logic [NUM_PINS-1:0] pad_oe_o
);
  logic wr, rd, mapped;
  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;
  assign mapped = (addr_i == A_OUT_SET) || (addr_i == A_OUT_CLR) ||
                  (addr_i == A_OE_SET) || (addr_i == A_OE_CLR) || (addr_i == A_PIN_IN);

  AST_OUT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == A_OUT_SET |=> ((pad_o & $past(wdata_i)) == $past(wdata_i)) &&
      ((pad_o & ~$past(wdata_i)) == ($past(pad_o) & ~$past(wdata_i))));  // R1
  AST_OUT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == A_OUT_CLR |=> ((pad_o & $past(wdata_i)) == '0) &&
      ((pad_o & ~$past(wdata_i)) == ($past(pad_o) & ~$past(wdata_i))));  // R2
  AST_OE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == A_OE_SET |=> ((pad_oe_o & $past(wdata_i)) == $past(wdata_i)) &&
      ((pad_oe_o & ~$past(wdata_i)) == ($past(pad_oe_o) & ~$past(wdata_i))));  // R3
  AST_OE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == A_OE_CLR |=> ((pad_oe_o & $past(wdata_i)) == '0) &&
      ((pad_oe_o & ~$past(wdata_i)) == ($past(pad_oe_o) & ~$past(wdata_i))));  // R4
  AST_RD_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && (addr_i == A_OUT_SET || addr_i == A_OUT_CLR) |=> rdata_o == $past(pad_o));  // R8
  AST_RD_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && (addr_i == A_OE_SET || addr_i == A_OE_CLR) |=> rdata_o == $past(pad_oe_o));  // R8
  AST_RD_UNMAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && !mapped |=> rdata_o == '0);  // R9
  AST_WR_UNMAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && !mapped |=> $stable(pad_o) && $stable(pad_oe_o));  // R9
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));  // R10
endmodule

bind gpio_setclr_port gpio_setclr_chk #(.NUM_PINS(NUM_PINS)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pad_o   (pad_o),
  .pad_oe_o(pad_oe_o)
);

// File: tb/test_gpio_setclr_port.sv
module test_gpio_setclr_port;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // {addr[4:0], mask, expected pad_o, expected pad_oe_o}
  localparam logic [100:0] VEC [NV] = '{
    {5'h00, 32'h0000_00F0, 32'h0000_00F0, 32'h0000_0000},  // R1
    {5'h08, 32'h0000_0FF0, 32'h0000_00F0, 32'h0000_0FF0},  // R3
    {5'h00, 32'h8000_0001, 32'h8000_00F1, 32'h0000_0FF0},  // R1
    {5'h04, 32'h0000_0030, 32'h8000_00C1, 32'h0000_0FF0},  // R2
    {5'h0C, 32'h0000_0300, 32'h8000_00C1, 32'h0000_0CF0},  // R4
    {5'h14, 32'hFFFF_FFFF, 32'h8000_00C1, 32'h0000_0CF0},  // R9
    {5'h04, 32'hFFFF_0000, 32'h0000_00C1, 32'h0000_0CF0},  // R2
    {5'h08, 32'hFFFF_FFFF, 32'h0000_00C1, 32'hFFFF_FFFF},  // R3
    {5'h0C, 32'hFFFF_FFFF, 32'h0000_00C1, 32'h0000_0000},  // R4
    {5'h00, 32'h0000_0000, 32'h0000_00C1, 32'h0000_0000}   // R1
  };

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, pad_i = '0;
  logic [31:0] rdata_o, pad_o, pad_oe_o;
  int checks = 0, errors = 0;
  logic [31:0] held;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_setclr_port i_gpio_setclr_port (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pad_i(pad_i), .pad_o(pad_o), .pad_oe_o(pad_oe_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(logic [4:0] a);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R7 pad_o", pad_o, 32'h0);
    check("R7 pad_oe_o", pad_oe_o, 32'h0);
    check("R7 rdata_o", rdata_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][100:96], VEC[i][95:64]);
      check("R1/R2 pad_o vector", pad_o, VEC[i][63:32]);
      check("R3/R4 pad_oe_o vector", pad_oe_o, VEC[i][31:0]);
    end

    wr(5'h08, 32'h0000_00FF);
    rd(5'h00); check("R8 read 0x00", rdata_o, 32'h0000_00C1);
    rd(5'h04); check("R8 read 0x04", rdata_o, 32'h0000_00C1);
    rd(5'h08); check("R8 read 0x08", rdata_o, 32'h0000_00FF);
    rd(5'h0C); check("R8 read 0x0C", rdata_o, 32'h0000_00FF);
    rd(5'h14); check("R9 read 0x14", rdata_o, 32'h0);
    rd(5'h1F); check("R9 read 0x1F", rdata_o, 32'h0);
    rd(5'h10); check("R5 input readback", rdata_o, 32'h0000_00C1);

    // R6: read accepted at first edge after pad change sees old level
    pad_i = 32'hA5A5_5A5A;
    rd(5'h10); check("R6 first edge old level", rdata_o, 32'h0000_00C1);
    repeat (2) @(negedge clk);
    rd(5'h10); check("R5 R6 synced mixed level", rdata_o, 32'hA5A5_5AC1);

    // R10: rdata holds through idle cycles and writes
    held = rdata_o;
    repeat (3) @(negedge clk);
    check("R10 hold idle", rdata_o, held);
    wr(5'h04, 32'h0000_0001);
    check("R10 hold on write", rdata_o, held);
    check("R2 single pin clear", pad_o, 32'h0000_00C0);
    wr(5'h1F, 32'hFFFF_FFFF);
    check("R9 unmapped write pad_o", pad_o, 32'h0000_00C0);
    check("R9 unmapped write pad_oe_o", pad_oe_o, 32'h0000_00FF);

    rst_ni = 1'b0;
    @(negedge clk);
    check("R7 re-reset pad_o", pad_o, 32'h0);
    check("R7 re-reset pad_oe_o", pad_oe_o, 32'h0);
    check("R7 re-reset rdata_o", rdata_o, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule